// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. It takes the memory from power-up to the idle-ready state, and it does so with no outside help. After reset it holds the device deselected for a programmable stabilisation period, with clock enable and the data mask held high. It then precharges every bank at once and waits the row-precharge time. Next it issues a programmable number of auto-refresh commands and a single mode-register load, in the order a parameter selects. After the last required gap it raises a done flag.

All delays are parameters counted in clock cycles, so an integrator derives them from the memory's timing figures and the clock frequency. The value loaded into the mode register is also a parameter. Between commands the sequencer drives NOP. A synchronous active-low reset restarts the whole sequence from the stabilisation wait at any point. Once the done flag is up, the command pins are free for the normal traffic logic.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the sequence restarts: from the next cycle on, the outputs are those of the first power-wait cycle and `init_done` is 0, even if reset arrives in the middle of the sequence.
- R2: For the first `PWR_WAIT_CYC` cycles after reset (cycle indices 0 to `PWR_WAIT_CYC`-1), the pins are deselect (`sd_cs_n`=1, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1), `sd_dqm`=1 and `sd_addr`=0.
- R3: At cycle index `PWR_WAIT_CYC` exactly one precharge-all is driven: `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, with `sd_addr` bit `PRE_ALL_BIT` (default 10) set and every other address bit 0.
- R4: The next command after the precharge-all comes exactly `TRP_CYC` cycles after it.
- R5: Exactly `NUM_REF` auto-refresh commands are issued (`sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=1, `sd_addr`=0), each following the one before it by exactly `TRC_CYC` cycles.
- R6: Exactly one mode-register load is issued (`sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=0) with `sd_addr` equal to `MODE_WORD`.
- R7: With `REF_BEFORE_MRS`=1 the refresh burst comes first and the mode-register load follows `TRC_CYC` cycles after the last refresh. With `REF_BEFORE_MRS`=0 the mode-register load comes first and the first refresh follows it by `TMRD_CYC` cycles.
- R8: `init_done` rises exactly `TMRD_CYC` cycles after the mode-register load (refresh-first order) or `TRC_CYC` cycles after the last refresh (load-first order). It then stays 1 until reset, with NOP on the pins, `sd_dqm`=0 and `sd_addr`=0.
- R9: In every cycle from the precharge-all until `init_done` that carries no command, the pins carry NOP (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1), `sd_dqm`=1 and `sd_addr`=0. So no command ever follows another in the next cycle.
- R10: `sd_cke` is 1 in every cycle, including during and straight after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | 1 | Data mask, high until initialization completes |
| sd_addr | output | ADDR_W | Address bus: precharge-all flag or mode word |
| init_done | output | 1 | High once the device is ready for normal commands |

## Verification
The hardest case to reach from the ports is a reset that lands partway through the sequence, after some refreshes have already gone out. If the refresh counter or the gap timer kept stale state, the restarted run would issue too few refreshes or mistime a gap. The stimulus pulses reset for a single cycle in the middle of the refresh burst, and later holds it for several cycles after completion. A behavioural cycle model, rebuilt from the command schedule, is compared on every cycle. Two instances run side by side, one for each refresh order and each with its own mode word, so that both successor paths and the order-dependent done timing are covered.

// File: rtl/sdram_init_pkg.sv
// Package: shared state and command-pin types for the SDRAM init sequencer.
// Assumes the usual SDRAM command truth table on CS#/RAS#/CAS#/WE#.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_PWR  = 3'd0,
        ST_PRE  = 3'd1,
        ST_TRP  = 3'd2,
        ST_REF  = 3'd3,
        ST_TRC  = 3'd4,
        ST_MRS  = 3'd5,
        ST_TMRD = 3'd6,
        ST_DONE = 3'd7
    } init_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESEL = sdr_cmd_t'(4'b1111);
    localparam sdr_cmd_t CMD_NOP   = sdr_cmd_t'(4'b0111);
    localparam sdr_cmd_t CMD_PRE   = sdr_cmd_t'(4'b0010);
    localparam sdr_cmd_t CMD_REF   = sdr_cmd_t'(4'b0001);
    localparam sdr_cmd_t CMD_MRS   = sdr_cmd_t'(4'b0000);

endpackage

// File: rtl/sdram_init_timer.sv
// Module: loadable down-counter used for every wait of the init sequence.
// Reset loads RST_VAL (the power-wait length minus one); a load takes priority
// over counting; the count holds at zero. Assumes load_val fits in CNT_W bits.
module sdram_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Counter register: reset value, reload, or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag for the sequencing FSM.
    assign expired = (cnt_q == '0);

    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));  // R4

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));  // R5

endmodule

// File: rtl/sdram_init_fsm.sv
// Module: sequencing FSM for SDRAM power-up. Walks power wait, precharge-all,
// refresh burst and mode load in the order picked by REF_BEFORE_MRS. Each
// command state lasts one cycle and loads the timer with gap-2, so the next
// command comes exactly gap cycles later. Assumes every gap is at least 2.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int TRP_CYC        = 3,
    parameter int TRC_CYC        = 8,
    parameter int TMRD_CYC       = 2,
    parameter int NUM_REF        = 8,
    parameter bit REF_BEFORE_MRS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output init_state_t      state_o
);

    localparam int REF_W = $clog2(NUM_REF + 1);
    localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_CYC - 2);
    localparam logic [CNT_W-1:0] TRC_LD  = CNT_W'(TRC_CYC - 2);
    localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_CYC - 2);

    init_state_t after_trp;
    init_state_t after_refs;
    init_state_t after_mrs;

    // Order-dependent successor states, chosen at elaboration.
    generate
        if (REF_BEFORE_MRS) begin : g_ref_first
            assign after_trp  = ST_REF;
            assign after_refs = ST_MRS;
            assign after_mrs  = ST_DONE;
        end else begin : g_mrs_first
            assign after_trp  = ST_MRS;
            assign after_refs = ST_DONE;
            assign after_mrs  = ST_REF;
        end
    endgenerate

    init_state_t      state_q, state_d;
    logic [REF_W-1:0] ref_cnt_q;
    logic             last_ref;

    assign last_ref = (ref_cnt_q == REF_W'(NUM_REF));

    // Next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_PWR:  if (tmr_expired) state_d = ST_PRE;
            ST_PRE:  begin tmr_load = 1'b1; tmr_val = TRP_LD;  state_d = ST_TRP;  end
            ST_TRP:  if (tmr_expired) state_d = after_trp;
            ST_REF:  begin tmr_load = 1'b1; tmr_val = TRC_LD;  state_d = ST_TRC;  end
            ST_TRC:  if (tmr_expired) state_d = last_ref ? after_refs : ST_REF;
            ST_MRS:  begin tmr_load = 1'b1; tmr_val = TMRD_LD; state_d = ST_TMRD; end
            ST_TMRD: if (tmr_expired) state_d = after_mrs;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_PWR;
        endcase
    end

    // State register with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR;
        else        state_q <= state_d;
    end

    // Count of refresh commands issued since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                ref_cnt_q <= '0;
        else if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end

    assign state_o = state_q;

    AST_REF_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt_q <= REF_W'(NUM_REF));  // R5

    AST_DONE_AFTER_ALL_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> last_ref);  // R5

    AST_REF_NOT_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF) |-> !last_ref);  // R5

endmodule

// File: rtl/sdram_init_cmd_drv.sv
// Module: turns the sequencer state into SDRAM pin levels. Deselect during the
// power wait, one command per command state, NOP otherwise; DQM stays high
// until the done state. Purely combinational from the state register.
module sdram_init_cmd_drv
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W      = 12,
    parameter int              PRE_ALL_BIT = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_state_t       state_i,
    output sdr_cmd_t          cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              dqm_o,
    output logic              done_o
);

    // Pin decode per state.
    always_comb begin
        cmd_o  = CMD_NOP;
        addr_o = '0;
        dqm_o  = 1'b1;
        done_o = 1'b0;
        case (state_i)
            ST_PWR:  cmd_o = CMD_DESEL;
            ST_PRE:  begin cmd_o = CMD_PRE; addr_o[PRE_ALL_BIT] = 1'b1; end
            ST_REF:  cmd_o = CMD_REF;
            ST_MRS:  begin cmd_o = CMD_MRS; addr_o = MODE_WORD; end
            ST_DONE: begin dqm_o = 1'b0; done_o = 1'b1; end
            default: cmd_o = CMD_NOP;
        endcase
    end

    logic is_cmd;
    assign is_cmd = !cmd_o.cs_n && !(cmd_o.ras_n && cmd_o.cas_n && cmd_o.we_n);

    AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> (cmd_o == CMD_NOP));  // R9

    AST_PRE_SETS_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> (addr_o[PRE_ALL_BIT] && $countones(addr_o) == 1));  // R3

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the SDRAM power-up initialization sequencer. Ties together
// the wait timer, the sequencing FSM and the pin driver. Clock enable is held
// high throughout. Assumes TRP_CYC, TRC_CYC and TMRD_CYC are at least 2 and
// that PWR_WAIT_CYC is at least 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W         = 12,
    parameter int              PRE_ALL_BIT    = 10,
    parameter int              PWR_WAIT_CYC   = 25000,
    parameter int              TRP_CYC        = 3,
    parameter int              TRC_CYC        = 9,
    parameter int              TMRD_CYC       = 2,
    parameter int              NUM_REF        = 8,
    parameter bit              REF_BEFORE_MRS = 1'b1,
    parameter logic [ADDR_W-1:0] MODE_WORD    = 12'h022
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic              sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int GAP_MAX_A = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int GAP_MAX   = (GAP_MAX_A > TMRD_CYC) ? GAP_MAX_A : TMRD_CYC;
    localparam int WAIT_MAX  = (PWR_WAIT_CYC > GAP_MAX) ? PWR_WAIT_CYC : GAP_MAX;
    localparam int CNT_W     = $clog2(WAIT_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    init_state_t      state;
    sdr_cmd_t         cmd;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWR_WAIT_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_init_fsm #(
        .CNT_W          (CNT_W),
        .TRP_CYC        (TRP_CYC),
        .TRC_CYC        (TRC_CYC),
        .TMRD_CYC       (TMRD_CYC),
        .NUM_REF        (NUM_REF),
        .REF_BEFORE_MRS (REF_BEFORE_MRS)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_o     (state)
    );

    sdram_init_cmd_drv #(
        .ADDR_W      (ADDR_W),
        .PRE_ALL_BIT (PRE_ALL_BIT),
        .MODE_WORD   (MODE_WORD)
    ) drv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .cmd_o   (cmd),
        .addr_o  (sd_addr),
        .dqm_o   (sd_dqm),
        .done_o  (init_done)
    );

    // Pin mapping; clock enable never drops.
    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_cke   = 1'b1;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);  // R8

    AST_DONE_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !sd_dqm));  // R8

    AST_PWR_WAIT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWR) |-> (sd_cs_n && sd_dqm && !init_done));  // R2

    AST_MRS_GAP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRS) |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));  // R6

endmodule

// File: tb/sdram_init_seq_tb_top.sv
// Bench: two sequencer instances (refresh-first and load-first) compared on
// every cycle against a behavioural schedule model built from the requirements.
module sdram_init_seq_tb_top;

    localparam int P    = 20;
    localparam int TRP  = 3;
    localparam int TRC  = 7;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam logic [11:0] MODE_A = 12'h032;
    localparam logic [11:0] MODE_B = 12'h2A7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
    logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
    logic [11:0] a_addr, b_addr;

    sdram_init_seq #(
        .PWR_WAIT_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
        .NUM_REF(NREF), .REF_BEFORE_MRS(1'b1), .MODE_WORD(MODE_A)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
        .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_cke(a_cke), .sd_dqm(a_dqm),
        .sd_addr(a_addr), .init_done(a_done)
    );

    sdram_init_seq #(
        .PWR_WAIT_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
        .NUM_REF(NREF), .REF_BEFORE_MRS(1'b0), .MODE_WORD(MODE_B)
    ) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
        .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_cke(b_cke), .sd_dqm(b_dqm),
        .sd_addr(b_addr), .init_done(b_done)
    );

    int compared = 0;
    int mismatched = 0;
    int k = 0;
    bit valid = 1'b0;
    bit finished = 1'b0;

    // Expected pin vector {cs,ras,cas,we,cke,dqm,done,addr[11:0]} at cycle k.
    function automatic logic [18:0] expect_at(input int kk, input bit ref_first,
                                              input logic [11:0] mode,
                                              output string tag);
        int first_ref, mrs_t, done_t;
        logic [11:0] pre_addr;
        pre_addr = 12'h400;
        if (ref_first) begin
            first_ref = P + TRP;
            mrs_t     = first_ref + NREF * TRC;
            done_t    = mrs_t + TMRD;
        end else begin
            mrs_t     = P + TRP;
            first_ref = mrs_t + TMRD;
            done_t    = first_ref + NREF * TRC;
        end
        if (kk < P) begin
            tag = (kk == 0) ? "R1 R2" : "R2";
            return {4'b1111, 1'b1, 1'b1, 1'b0, 12'h000};
        end
        if (kk == P) begin
            tag = "R3";
            return {4'b0010, 1'b1, 1'b1, 1'b0, pre_addr};
        end
        if (kk >= done_t) begin
            tag = "R8";
            return {4'b0111, 1'b1, 1'b0, 1'b1, 12'h000};
        end
        if (kk == mrs_t) begin
            tag = (kk == P + TRP) ? "R4 R6 R7" : "R6 R7";
            return {4'b0000, 1'b1, 1'b1, 1'b0, mode};
        end
        for (int i = 0; i < NREF; i++) begin
            if (kk == first_ref + i * TRC) begin
                tag = (kk == P + TRP) ? "R4 R5 R7" : "R5 R7";
                return {4'b0001, 1'b1, 1'b1, 1'b0, 12'h000};
            end
        end
        tag = "R9 R10";
        return {4'b0111, 1'b1, 1'b1, 1'b0, 12'h000};
    endfunction

    task automatic check(input string who, input logic [18:0] act,
                         input logic [18:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d actual=%05h expected=%05h", tag, who, k, act, exp);
        end
    endtask

    // Cycle index of the model: restarts on any reset edge (R1).
    always @(posedge clk) begin
        if (!rst_n) begin
            k <= 0;
            valid <= 1'b1;
        end else if (valid) begin
            k <= k + 1;
        end
    end

    // Compare both instances every cycle, away from the active edge.
    always @(negedge clk) begin
        if (valid && !finished) begin
            string ta, tb;
            logic [18:0] ea, eb;
            ea = expect_at(k, 1'b1, MODE_A, ta);
            eb = expect_at(k, 1'b0, MODE_B, tb);
            check("refresh-first", {a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done, a_addr}, ea, ta);
            check("load-first",    {b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done, b_addr}, eb, tb);
        end
    end

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        run_cycles(3);
        rst_n = 1'b1;
        // Into the refresh burst, then a one-cycle reset (R1).
        run_cycles(50);
        rst_n = 1'b0;
        run_cycles(1);
        rst_n = 1'b1;
        // Full sequence to done and a stretch of idle (R8).
        run_cycles(140);
        rst_n = 1'b0;
        run_cycles(4);
        rst_n = 1'b1;
        run_cycles(130);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 5000);
        if (!finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL R8 watchdog expired at cycle %0d actual=running expected=finished", k);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule